// File: doc/BRIEF.md
# Loop Divider and Phase-Frequency Comparator

This block is the digital heart of a frequency synthesiser loop. It counts rising edges of the prescaled oscillator signal and divides them by a programmable ratio N. It counts rising edges of the reference signal and divides them by a fixed factor (512 by default) to form the comparison rate. A two-flop phase-frequency comparator turns the two divided streams into pump-up and pump-down pulses. A lock detector raises a flag once the loop has settled. With a 4 MHz reference the comparison rate is 7.8125 kHz. The output frequency is therefore 8 × N × that rate, counting the external divide-by-8 prescaler that sits ahead of this block.

Both inputs are treated as slow signals. They are synchronised into one fast system clock, and their rising edges become one-cycle pulses. All counting and comparison therefore happens in a single clock domain. A disable bit silences the pump outputs. A current-select bit is passed straight through. A test bit replaces the states programmed for two general-purpose outputs with the comparison clock and the divided oscillator clock.

Top module: `pll_digital_core`

## Requirements
- R1: The reference divider emits one comparison event for every REF_DIV (default 512) synchronised rising edges of `ref_in`. Its divided clock is high while its down-counter is below half of the ratio.
- R2: The oscillator divider emits one divided event for every N rising edges of `osc_in`, where N is `div_ratio`. The ratio is captured only at terminal count, so a change takes effect at the next reload.
- R3: A `div_ratio` of 0 or 1 is treated as 2.
- R4: The comparator's up flop sets on a comparison event and its down flop sets on a divided event. When both are set, both clear on the next clock. When the divided stream runs fast, down pulses dominate; when it runs slow, up pulses dominate.
- R5: While `pump_off` is 1, `pump_up` and `pump_dn` are both 0.
- R6: `cur_sel` equals `cur_hi` at all times.
- R7: `locked` rises after LOCK_CYC (default 4) consecutive comparisons in which the one-sided pulse lasted at most LOCK_WIN (default 4) clocks. It falls on the first clock in which a one-sided pulse exceeds that window.
- R8: With `test_en` = 1, `aux_a` carries the comparison clock and `aux_b` carries the divided oscillator clock. With `test_en` = 0 they carry `aux_a_set` and `aux_b_set`.
- R9: Synchronous active-low reset clears all counters and the comparator. `pump_up`, `pump_dn` and `locked` are 0 during reset and remain 0 until input edges arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_in | input | 1 | Prescaled oscillator signal, asynchronous |
| ref_in | input | 1 | Reference signal, asynchronous |
| div_ratio | input | NW | Programmable oscillator division ratio N |
| pump_off | input | 1 | 1 forces both pump outputs inactive |
| cur_hi | input | 1 | Pump current select, high when 1 |
| test_en | input | 1 | Routes internal clocks to the aux outputs |
| aux_a_set | input | 1 | Programmed state of general output A |
| aux_b_set | input | 1 | Programmed state of general output B |
| pump_up | output | 1 | Pump-up pulse |
| pump_dn | output | 1 | Pump-down pulse |
| cur_sel | output | 1 | Pump current select to the analog pump |
| locked | output | 1 | Lock flag |
| aux_a | output | 1 | General output A or comparison clock |
| aux_b | output | 1 | General output B or divided oscillator clock |

## Verification
On every cycle the assertions check the following. The pump outputs stay quiet while disabled. The comparator never holds both flops set for two cycles. A divider's captured ratio changes only at its terminal count and never falls below 2. The lock flag rises only right after a comparison closes. Division rates, the clamp of small ratios, the test routing, and which pump direction dominates under a frequency error depend on long input patterns. Only the bench's scenarios show those, by counting output edges and pulse cycles over windows. The same holds for lock being gained after a settled run and lost after the ratio is detuned.

// File: rtl/pdc_pkg.sv
// Shared types for the loop divider and phase comparator.
// Assumes: nothing beyond IEEE 1800-2017.
package pdc_pkg;

    // Pair of comparator flop states.
    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

endpackage

// File: rtl/pdc_edge_sync.sv
// Synchronises an asynchronous slow signal and emits a one-cycle pulse
// on each rising edge.
// Assumes: the input stays high and low for at least two clk periods each;
// SYNC >= 2.
module pdc_edge_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic [SYNC-1:0] sreg;
    logic            last;

    // First synchroniser stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sreg[0] <= 1'b0;
        else        sreg[0] <= sig_i;
    end

    // Remaining synchroniser stages, one per generate step.
    for (genvar i = 1; i < SYNC; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) sreg[i] <= 1'b0;
            else        sreg[i] <= sreg[i-1];
        end
    end

    // Delayed copy of the synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= sreg[SYNC-1];
    end

    assign rise_o = sreg[SYNC-1] & ~last;
endmodule

// File: rtl/pdc_divider.sv
// Edge-counting divider: one tick per N input pulses, with N captured at
// terminal count. Ratios below 2 are treated as 2.
// Assumes: edge_i is a one-cycle pulse in the clk domain.
module pdc_divider #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_i,
    input  logic [W-1:0] ratio_i,
    output logic         tick_o,
    output logic         lvl_o,
    output logic [W-1:0] n_o
);
    localparam logic [W-1:0] MIN_N = W'(2);

    logic [W-1:0] cnt;
    logic [W-1:0] cur_n;
    logic [W-1:0] n_eff;

    // Clamp the requested ratio to the smallest legal value.
    always_comb n_eff = (ratio_i < MIN_N) ? MIN_N : ratio_i;

    // Down-counter with reload on terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            cur_n  <= n_eff;
            tick_o <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (edge_i) begin
                if (cnt == '0) begin
                    cnt    <= n_eff - W'(1);
                    cur_n  <= n_eff;
                    tick_o <= 1'b1;
                end else begin
                    cnt <= cnt - W'(1);
                end
            end
        end
    end

    assign lvl_o = (cnt < (cur_n >> 1));
    assign n_o   = cur_n;
endmodule

// File: rtl/pdc_pfd_lock.sv
// Two-flop phase-frequency comparator with a pulse-width lock detector.
// Assumes: cmp_tick_i and dvd_tick_i are one-cycle pulses.
module pdc_pfd_lock
    import pdc_pkg::*;
#(
    parameter int LOCK_WIN = 4,
    parameter int LOCK_CYC = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cmp_tick_i,
    input  logic  dvd_tick_i,
    output pump_t flops_o,
    output logic  locked_o
);
    localparam int WCW = $clog2(LOCK_WIN + 2);
    localparam int GCW = $clog2(LOCK_CYC + 1);
    localparam logic [WCW-1:0] WIN_V = WCW'(LOCK_WIN);
    localparam logic [GCW-1:0] CYC_V = GCW'(LOCK_CYC);

    pump_t          st;
    logic [WCW-1:0] wcnt;
    logic [GCW-1:0] good;

    // Comparator flops: set by their events, cleared together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (st.up && st.dn) begin
            st <= '0;
        end else begin
            if (cmp_tick_i) st.up <= 1'b1;
            if (dvd_tick_i) st.dn <= 1'b1;
        end
    end

    // Measure one-sided pulse width and qualify consecutive comparisons.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt     <= '0;
            good     <= '0;
            locked_o <= 1'b0;
        end else if (st.up && st.dn) begin
            wcnt <= '0;
            if (wcnt <= WIN_V) begin
                if (good != CYC_V) good <= good + GCW'(1);
                if (good >= CYC_V - GCW'(1)) locked_o <= 1'b1;
            end
        end else if (st.up ^ st.dn) begin
            if (wcnt > WIN_V) begin
                good     <= '0;
                locked_o <= 1'b0;
            end else begin
                wcnt <= wcnt + WCW'(1);
            end
        end
    end

    assign flops_o = st;
endmodule

// File: rtl/pll_digital_core.sv
// Top of the loop's digital core: input edge capture, reference and
// oscillator dividers, comparator, lock detector, pump gating and test
// routing of the two general outputs.
// Assumes: osc_in and ref_in are much slower than clk.
module pll_digital_core
    import pdc_pkg::*;
#(
    parameter int NW       = 15,
    parameter int REF_DIV  = 512,
    parameter int SYNC     = 2,
    parameter int LOCK_WIN = 4,
    parameter int LOCK_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          osc_in,
    input  logic          ref_in,
    input  logic [NW-1:0] div_ratio,
    input  logic          pump_off,
    input  logic          cur_hi,
    input  logic          test_en,
    input  logic          aux_a_set,
    input  logic          aux_b_set,
    output logic          pump_up,
    output logic          pump_dn,
    output logic          cur_sel,
    output logic          locked,
    output logic          aux_a,
    output logic          aux_b
);
    localparam logic [NW-1:0] REF_RATIO = NW'(REF_DIV);

    logic          osc_rise, ref_rise;
    logic          cmp_tick, dvd_tick;
    logic          cmp_lvl, dvd_lvl;
    logic [NW-1:0] cmp_n, dvd_n;
    pump_t         flops;
    logic          pfd_up, pfd_dn;

    pdc_edge_sync #(.SYNC(SYNC)) u_osc_sync (
        .clk(clk), .rst_n(rst_n), .sig_i(osc_in), .rise_o(osc_rise));

    pdc_edge_sync #(.SYNC(SYNC)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .sig_i(ref_in), .rise_o(ref_rise));

    pdc_divider #(.W(NW)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .edge_i(ref_rise), .ratio_i(REF_RATIO),
        .tick_o(cmp_tick), .lvl_o(cmp_lvl), .n_o(cmp_n));

    pdc_divider #(.W(NW)) u_osc_div (
        .clk(clk), .rst_n(rst_n), .edge_i(osc_rise), .ratio_i(div_ratio),
        .tick_o(dvd_tick), .lvl_o(dvd_lvl), .n_o(dvd_n));

    pdc_pfd_lock #(.LOCK_WIN(LOCK_WIN), .LOCK_CYC(LOCK_CYC)) u_pfd (
        .clk(clk), .rst_n(rst_n), .cmp_tick_i(cmp_tick),
        .dvd_tick_i(dvd_tick), .flops_o(flops), .locked_o(locked));

    // Output gating and test routing.
    always_comb begin
        pfd_up  = flops.up;
        pfd_dn  = flops.dn;
        pump_up = pfd_up & ~pump_off;
        pump_dn = pfd_dn & ~pump_off;
        cur_sel = cur_hi;
        aux_a   = test_en ? cmp_lvl : aux_a_set;
        aux_b   = test_en ? dvd_lvl : aux_b_set;
    end
endmodule

// File: rtl/pll_digital_core_chk.sv
// Cycle-level checks on the loop core, bound to the top module.
// Assumes: signals are sampled on the rising clk edge.
module pll_digital_core_chk #(
    parameter int NW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pump_off,
    input logic          pump_up,
    input logic          pump_dn,
    input logic          locked,
    input logic          pfd_up,
    input logic          pfd_dn,
    input logic          cmp_tick,
    input logic          dvd_tick,
    input logic [NW-1:0] cmp_n,
    input logic [NW-1:0] dvd_n
);
    // R5: disabled pump stays quiet.
    a_r5_pump_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pump_off |-> (!pump_up && !pump_dn));

    // R4: both comparator flops never stay set for two cycles.
    a_r4_joint_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pfd_up && pfd_dn) |=> !(pfd_up && pfd_dn));

    // R2: oscillator ratio is captured only at terminal count.
    a_r2_osc_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (dvd_n != $past(dvd_n)) |-> dvd_tick);

    // R1: reference ratio is captured only at terminal count.
    a_r1_ref_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_n != $past(cmp_n)) |-> cmp_tick);

    // R3: captured ratio is never below 2.
    a_r3_min_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        dvd_n >= NW'(2));

    // R7: lock rises only right after a comparison closes.
    a_r7_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(pfd_up && pfd_dn));
endmodule

bind pll_digital_core pll_digital_core_chk #(.NW(NW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pump_off(pump_off), .pump_up(pump_up),
    .pump_dn(pump_dn), .locked(locked), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
    .cmp_tick(cmp_tick), .dvd_tick(dvd_tick), .cmp_n(cmp_n), .dvd_n(dvd_n));

// File: tb/tb_pll_digital_core.sv
// Scoreboard bench: tasks push expected items, measurements push observed
// values, and a monitor pops and compares them pairwise.
module tb_pll_digital_core;
    localparam int NW = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_in = 1'b0, ref_in = 1'b0;
    logic [NW-1:0] div_ratio = NW'(512);
    logic pump_off = 1'b0, cur_hi = 1'b0, test_en = 1'b0;
    logic aux_a_set = 1'b0, aux_b_set = 1'b0;
    logic pump_up, pump_dn, cur_sel, locked, aux_a, aux_b;

    int ref_half = 2;
    int osc_half = 2;
    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        string req;
        int    exp;
        int    tol;
    } exp_t;

    exp_t exp_q[$];
    int   obs_q[$];

    always #10 clk = ~clk;

    pll_digital_core #(.NW(NW)) dut (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .ref_in(ref_in),
        .div_ratio(div_ratio), .pump_off(pump_off), .cur_hi(cur_hi),
        .test_en(test_en), .aux_a_set(aux_a_set), .aux_b_set(aux_b_set),
        .pump_up(pump_up), .pump_dn(pump_dn), .cur_sel(cur_sel),
        .locked(locked), .aux_a(aux_a), .aux_b(aux_b));

    // Input square-wave generator, restarted in phase at every reset.
    initial begin
        int rc = 0;
        int oc = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rc = 0; oc = 0; ref_in = 1'b0; osc_in = 1'b0;
            end else begin
                rc++; oc++;
                if (rc >= ref_half) begin rc = 0; ref_in = ~ref_in; end
                if (oc >= osc_half) begin oc = 0; osc_in = ~osc_in; end
            end
        end
    end

    // Monitor: compare each observed value with its expected item.
    initial begin
        forever begin
            exp_t e;
            int   o;
            wait (exp_q.size() > 0 && obs_q.size() > 0);
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            total++;
            if (o < e.exp - e.tol || o > e.exp + e.tol) begin
                bad++;
                $display("FAIL %s: actual=%0d expected=%0d (tol %0d)",
                         e.req, o, e.exp, e.tol);
            end
        end
    end

    function automatic int sig(input int s);
        case (s)
            0: return int'(pump_up);
            1: return int'(pump_dn);
            2: return int'(locked);
            3: return int'(cur_sel);
            4: return int'(aux_a);
            5: return int'(aux_b);
            default: return 0;
        endcase
    endfunction

    task automatic expect_item(input string req, input int e, input int tol);
        exp_t it;
        it.req = req; it.exp = e; it.tol = tol;
        exp_q.push_back(it);
    endtask

    task automatic check_now(input string req, input int s, input int e);
        @(negedge clk);
        expect_item(req, e, 0);
        obs_q.push_back(sig(s));
    endtask

    task automatic count_rises(input string req, input int s, input int win,
                               input int e, input int tol);
        int n = 0;
        int prev;
        @(negedge clk);
        prev = sig(s);
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (sig(s) == 1 && prev == 0) n++;
            prev = sig(s);
        end
        expect_item(req, e, tol);
        obs_q.push_back(n);
    endtask

    task automatic count_high(input string req, input int s, input int win,
                              input int e, input int tol);
        int n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (sig(s) == 1) n++;
        end
        expect_item(req, e, tol);
        obs_q.push_back(n);
    endtask

    // 1 when down-only cycles exceed up-only cycles over the window.
    task automatic dn_dominates(input string req, input int win, input int e);
        int nu = 0;
        int nd = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (pump_up && !pump_dn) nu++;
            if (pump_dn && !pump_up) nd++;
        end
        expect_item(req, e, 0);
        obs_q.push_back((nd > nu) ? 1 : 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state, then no edges yet.
        ref_half = 1000000; osc_half = 1000000;
        @(negedge clk);
        check_now("R9 up in reset", 0, 0);
        check_now("R9 dn in reset", 1, 0);
        check_now("R9 lock in reset", 2, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check_now("R9 lock idle", 2, 0);
        check_now("R9 up idle", 0, 0);

        // R6: current select mirrors its input.
        cur_hi = 1'b1; check_now("R6 cur high", 3, 1);
        cur_hi = 1'b0; check_now("R6 cur low", 3, 0);

        // R8: programmed states when not in test mode.
        aux_a_set = 1'b1; aux_b_set = 1'b0;
        check_now("R8 aux_a prog", 4, 1);
        check_now("R8 aux_b prog", 5, 0);
        aux_a_set = 1'b0; aux_b_set = 1'b1;
        check_now("R8 aux_a prog swap", 4, 0);
        check_now("R8 aux_b prog swap", 5, 1);

        // R7: matched loop (512*4 clk on both sides) gains lock.
        ref_half = 2; osc_half = 2; div_ratio = NW'(512);
        do_reset();
        repeat (4000) @(negedge clk);
        check_now("R7 not yet locked", 2, 0);
        repeat (5000) @(negedge clk);
        check_now("R7 locked after settled run", 2, 1);

        // R7: detuned ratio (500) loses lock.
        div_ratio = NW'(500);
        repeat (3 * 2048 + 100) @(negedge clk);
        check_now("R7 lock lost after detune", 2, 0);

        // R5: disabled pump emits nothing despite the error.
        pump_off = 1'b1;
        count_high("R5 up silent", 0, 3000, 0, 0);
        count_high("R5 dn silent", 1, 3000, 0, 0);
        pump_off = 1'b0;

        // R4: fast divided stream -> down dominates.
        div_ratio = NW'(500);
        do_reset();
        dn_dominates("R4 fast divided gives down", 6000, 1);

        // R4: slow divided stream -> up dominates.
        div_ratio = NW'(530);
        do_reset();
        dn_dominates("R4 slow divided gives up", 6000, 0);

        // R1, R2: division rates seen through test routing.
        test_en = 1'b1; div_ratio = NW'(64);
        do_reset();
        count_rises("R1 comparison clock rate", 4, 8192, 4, 1);
        count_rises("R2 divided clock rate N=64", 5, 8192, 32, 1);

        // R3: ratios 1 and 0 clamp to 2; ratio 3 for contrast.
        div_ratio = NW'(1);
        repeat (300) @(negedge clk);
        count_rises("R3 ratio 1 acts as 2", 5, 800, 100, 2);
        div_ratio = NW'(0);
        repeat (50) @(negedge clk);
        count_rises("R3 ratio 0 acts as 2", 5, 800, 100, 2);
        div_ratio = NW'(3);
        repeat (50) @(negedge clk);
        count_rises("R2 ratio 3", 5, 800, 67, 2);
        test_en = 1'b0;

        wait (exp_q.size() == 0 && obs_q.size() == 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule